// File: doc/BRIEF.md
# UART FIFO Interrupt Request Generator

This block forms the receive and transmit interrupt requests of a UART whose receive and transmit FIFOs each hold 64 characters. It does not contain the FIFOs. It is fed the live fill count of each FIFO, the enable bits, a strobe for each character pushed into the receive FIFO, a strobe for each transmit holding register write, and a strobe for each read of the interrupt identification register. From these it produces the following outputs:

- a receive-data-available request
- a transmit-data-request
- a priority-encoded identification code
- the Data Ready status bit
- a sticky transmit overflow flag
- a single combined interrupt line

The receive request depends only on the current level. It stays high while the receive FIFO count is at or above a trigger chosen from four levels. It drops without any acknowledge once the count falls below that trigger. The transmit request works differently. It is armed when the transmit FIFO count crosses into one of two selectable conditions: half empty or fully empty. A holding-register write or an identification read then clears it. It does not rise again until the count leaves the condition and enters it once more.

All request and status outputs are registered. Each one reflects the inputs sampled at the previous rising clock edge.

Top module: `uart_fifo_irq`

## Requirements
- R1: `rx_irq` is 0 one edge after a cycle in which `fifo_en` or `rx_int_en` is 0.
- R2: With both receive enables at 1, `rx_irq` is 1 one edge after a cycle in which `rx_count` is at or above the selected trigger level.
- R3: `rx_irq` returns to 0 one edge after `rx_count` falls below the trigger. No acknowledge strobe is needed.
- R4: `rx_trig_sel` selects the receive trigger as follows: 0 gives 1 entry, 1 gives 16, 2 gives 32 and 3 gives 56.
- R5: `data_ready` sets one edge after `rx_push`. It stays set while `rx_count` is non-zero and clears one edge after `rx_count` reads 0 with no push. A non-zero count without a push does not set it.
- R6: `tx_irq` is 0 one edge after a cycle in which `fifo_en` or `tx_int_en` is 0.
- R7: With `tx_lvl_sel`=0, `tx_irq` rises one edge after `tx_count` enters the range 32 or fewer. It falls one edge after the count rises above 32.
- R8: With `tx_lvl_sel`=1, `tx_irq` rises only when `tx_count` becomes 0.
- R9: A cycle with `thr_wr` or `iir_rd` high clears `tx_irq` one edge later, in both transmit modes.
- R10: After a clear by strobe, `tx_irq` stays 0 while the transmit condition persists. It re-arms only on a new entry into the condition.
- R11: `thr_wr` while `tx_count` equals 64 sets `tx_overflow` one edge later. The flag stays set until reset. A write at a lower count leaves it unchanged.
- R12: `iid` is 3'b100 when `rx_irq` is set. Otherwise it is 3'b010 when `tx_irq` is set, and 3'b001 when neither is set.
- R13: `irq` is the OR of `rx_irq` and `tx_irq`. After reset every flag is 0 and `iid` is 3'b001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFO mode enable |
| rx_int_en | input | 1 | Receive interrupt enable |
| tx_int_en | input | 1 | Transmit interrupt enable |
| tx_lvl_sel | input | 1 | Transmit level: 0 = half empty, 1 = empty |
| rx_trig_sel | input | 2 | Receive trigger select |
| rx_count | input | 7 | Receive FIFO fill count (0 to 64) |
| rx_push | input | 1 | A character entered the receive FIFO |
| tx_count | input | 7 | Transmit FIFO fill count (0 to 64) |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iir_rd | input | 1 | Identification register read strobe |
| rx_irq | output | 1 | Receive data available request |
| tx_irq | output | 1 | Transmit data request |
| iid | output | 3 | Highest pending source code |
| data_ready | output | 1 | Receive FIFO holds data |
| tx_overflow | output | 1 | Sticky transmit overflow flag |
| irq | output | 1 | Combined interrupt line |

## Verification
Every flag is due exactly one rising edge after the inputs that cause it. `iid` and `irq` are decoded from those flags, so they settle in that same cycle. The bench changes its inputs one time unit after a rising edge and reads outputs one time unit after the next rising edge. A strobe is therefore held for exactly one edge, and its effect is read right after that edge. Negative checks, such as no re-arm while the condition persists, are sampled at one or more further edges with the inputs held still.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   typedef enum logic [2:0] {
      IID_NONE = 3'b001,
      IID_TXRQ = 3'b010,
      IID_RXDA = 3'b100
   } iid_e;
endpackage

// File: rtl/uart_rx_irq.sv
module uart_rx_irq #(
   parameter int DEPTH = 64,
   parameter int CNT_W = 7,
   parameter int TRIG0 = 1,
   parameter int TRIG1 = 16,
   parameter int TRIG2 = 32,
   parameter int TRIG3 = 56
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [1:0]       trig_sel,
   input  logic [CNT_W-1:0] count,
   input  logic             push,
   output logic             rx_irq,
   output logic             data_ready
);
   localparam int TRIG_TAB [4] = '{TRIG0, TRIG1, TRIG2, TRIG3};

   logic [3:0] at_lvl;

   for (genvar g = 0; g < 4; g++) begin : g_trig
      if (TRIG_TAB[g] < 1 || TRIG_TAB[g] > DEPTH) begin : g_bad
         $error("receive trigger level out of range");
      end
      assign at_lvl[g] = (count >= CNT_W'(TRIG_TAB[g]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_irq     <= 1'b0;
         data_ready <= 1'b0;
      end else begin
         rx_irq <= en && at_lvl[trig_sel];
         if (push)
            data_ready <= 1'b1;
         else if (count == '0)
            data_ready <= 1'b0;
      end
   end

   // R1
   rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !rx_irq);

   // R5
   dr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> data_ready);
endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq #(
   parameter int DEPTH = 64,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             lvl_sel,
   input  logic [CNT_W-1:0] count,
   input  logic             thr_wr,
   input  logic             iir_rd,
   output logic             tx_irq,
   output logic             overflow
);
   localparam int HALF = DEPTH / 2;
   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   if (DEPTH < 2 || CNT_W < $clog2(DEPTH + 1)) begin : g_bad
      $error("transmit depth or count width invalid");
   end

   logic full, cond, cond_q, clr;

   if (POW2) begin : g_full_msb
      assign full = count[CNT_W-1];
   end else begin : g_full_cmp
      assign full = (count == CNT_W'(DEPTH));
   end

   assign cond = en && (lvl_sel ? (count == '0) : (count <= CNT_W'(HALF)));
   assign clr  = thr_wr || iir_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_q   <= 1'b0;
         tx_irq   <= 1'b0;
         overflow <= 1'b0;
      end else begin
         cond_q <= cond;
         if (!cond || clr)
            tx_irq <= 1'b0;
         else if (!cond_q)
            tx_irq <= 1'b1;
         if (thr_wr && full)
            overflow <= 1'b1;
      end
   end

   // R9
   tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr || iir_rd) |=> !tx_irq);

   // R10
   tx_rise_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_irq) |-> $past(en));

   // R11
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
   import uart_irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_irq,
   input  logic       tx_irq,
   output logic [2:0] iid,
   output logic       irq
);
   iid_e code;

   always_comb begin
      if (rx_irq)      code = IID_RXDA;
      else if (tx_irq) code = IID_TXRQ;
      else             code = IID_NONE;
   end

   assign iid = code;
   assign irq = rx_irq || tx_irq;

   // R12
   rx_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> (iid == 3'b100));

   // R13
   irq_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (iid != 3'b001));
endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq #(
   parameter int DEPTH = 64,
   parameter int TRIG0 = 1,
   parameter int TRIG1 = 16,
   parameter int TRIG2 = 32,
   parameter int TRIG3 = 56
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fifo_en,
   input  logic       rx_int_en,
   input  logic       tx_int_en,
   input  logic       tx_lvl_sel,
   input  logic [1:0] rx_trig_sel,
   input  logic [6:0] rx_count,
   input  logic       rx_push,
   input  logic [6:0] tx_count,
   input  logic       thr_wr,
   input  logic       iir_rd,
   output logic       rx_irq,
   output logic       tx_irq,
   output logic [2:0] iid,
   output logic       data_ready,
   output logic       tx_overflow,
   output logic       irq
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (CNT_W != 7) begin : g_bad
      $error("count ports are sized for a 64-entry FIFO");
   end

   uart_rx_irq #(
      .DEPTH(DEPTH), .CNT_W(CNT_W),
      .TRIG0(TRIG0), .TRIG1(TRIG1), .TRIG2(TRIG2), .TRIG3(TRIG3)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (fifo_en && rx_int_en),
      .trig_sel   (rx_trig_sel),
      .count      (rx_count),
      .push       (rx_push),
      .rx_irq     (rx_irq),
      .data_ready (data_ready)
   );

   uart_tx_irq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (fifo_en && tx_int_en),
      .lvl_sel  (tx_lvl_sel),
      .count    (tx_count),
      .thr_wr   (thr_wr),
      .iir_rd   (iir_rd),
      .tx_irq   (tx_irq),
      .overflow (tx_overflow)
   );

   uart_irq_id u_id (
      .clk    (clk),
      .rst_n  (rst_n),
      .rx_irq (rx_irq),
      .tx_irq (tx_irq),
      .iid    (iid),
      .irq    (irq)
   );
endmodule

// File: tb/uart_fifo_irq_tb.sv
module uart_fifo_irq_tb;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic fifo_en = 0, rx_int_en = 0, tx_int_en = 0, tx_lvl_sel = 0;
   logic [1:0] rx_trig_sel = 0;
   logic [6:0] rx_count = 0, tx_count = 0;
   logic rx_push = 0, thr_wr = 0, iir_rd = 0;
   logic rx_irq, tx_irq, data_ready, tx_overflow, irq;
   logic [2:0] iid;
   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_fifo_irq u_dut (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_int_en(rx_int_en),
      .tx_int_en(tx_int_en), .tx_lvl_sel(tx_lvl_sel), .rx_trig_sel(rx_trig_sel),
      .rx_count(rx_count), .rx_push(rx_push), .tx_count(tx_count),
      .thr_wr(thr_wr), .iir_rd(iir_rd), .rx_irq(rx_irq), .tx_irq(tx_irq),
      .iid(iid), .data_ready(data_ready), .tx_overflow(tx_overflow), .irq(irq)
   );

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic t_reset();
      // R13 reset state
      chk("R13 rx_irq", rx_irq, 0);
      chk("R13 tx_irq", tx_irq, 0);
      chk("R13 iid", iid, 3'b001);
      chk("R13 irq", irq, 0);
      chk("R13 dr", data_ready, 0);
      chk("R13 ovf", tx_overflow, 0);
   endtask

   task automatic t_rx_trig();
      int lv [4] = '{1, 16, 32, 56};
      fifo_en = 1; rx_int_en = 1;
      for (int s = 0; s < 4; s++) begin
         rx_trig_sel = 2'(s);
         rx_count = 7'(lv[s] - 1); tick();
         chk("R4 below trigger", rx_irq, 0);
         rx_count = 7'(lv[s]); tick();
         chk("R2 at trigger", rx_irq, 1);
         chk("R12 iid rx", iid, 3'b100);
         chk("R13 irq", irq, 1);
         rx_count = 7'(lv[s] - 1); tick();
         chk("R3 drop below", rx_irq, 0);
      end
      rx_count = 0; tick();
   endtask

   task automatic t_rx_gate();
      rx_trig_sel = 0; rx_count = 60; rx_int_en = 0; tick();
      chk("R1 rx_int_en off", rx_irq, 0);
      rx_int_en = 1; fifo_en = 0; tick();
      chk("R1 fifo_en off", rx_irq, 0);
      fifo_en = 1; rx_count = 0; rx_int_en = 0; tick();
   endtask

   task automatic t_dr();
      rx_count = 3; tick();
      chk("R5 count without push", data_ready, 0);
      rx_count = 0; tick();
      rx_push = 1; tick();
      rx_push = 0; rx_count = 1;
      chk("R5 set on push", data_ready, 1);
      rx_count = 5; tick();
      chk("R5 hold", data_ready, 1);
      rx_count = 0; tick();
      chk("R5 clear on empty", data_ready, 0);
   endtask

   task automatic t_tx_half();
      tx_int_en = 1; tx_lvl_sel = 0; tx_count = 40; tick();
      chk("R7 above half", tx_irq, 0);
      tx_count = 33; tick();
      chk("R7 at 33", tx_irq, 0);
      tx_count = 32; tick();
      chk("R7 at 32", tx_irq, 1);
      chk("R12 iid tx", iid, 3'b010);
      tx_count = 33; tick();
      chk("R7 back above", tx_irq, 0);
   endtask

   task automatic t_tx_empty();
      tx_lvl_sel = 1; tx_count = 10; tick();
      chk("R8 non-empty", tx_irq, 0);
      tx_count = 0; tick();
      chk("R8 empty", tx_irq, 1);
   endtask

   task automatic t_clear();
      thr_wr = 1; tick(); thr_wr = 0;
      chk("R9 thr_wr clears", tx_irq, 0);
      tick(); tick();
      chk("R10 no re-raise", tx_irq, 0);
      tx_count = 5; tick(); tx_count = 0; tick();
      chk("R10 re-arm", tx_irq, 1);
      iir_rd = 1; tick(); iir_rd = 0;
      chk("R9 iir_rd clears", tx_irq, 0);
      tick();
      chk("R10 stays clear", tx_irq, 0);
      chk("R12 iid none", iid, 3'b001);
   endtask

   task automatic t_prio();
      tx_count = 5; tick(); tx_count = 0; tick();
      rx_int_en = 1; rx_count = 60; tick();
      chk("R12 rx over tx", iid, 3'b100);
      chk("R13 irq", irq, 1);
      rx_count = 0; tick();
      chk("R12 tx after rx", iid, 3'b010);
      rx_int_en = 0;
   endtask

   task automatic t_tx_gate();
      tx_int_en = 0; tick();
      chk("R6 tx_int_en off", tx_irq, 0);
      tx_count = 5; tick(); tx_count = 0; tick();
      chk("R6 no request when disabled", tx_irq, 0);
      tx_int_en = 1; fifo_en = 0; tick();
      chk("R6 fifo_en off", tx_irq, 0);
      fifo_en = 1;
   endtask

   task automatic t_ovf();
      tx_count = 63; thr_wr = 1; tick(); thr_wr = 0;
      chk("R11 write at 63", tx_overflow, 0);
      tx_count = 64; thr_wr = 1; tick(); thr_wr = 0;
      chk("R11 write when full", tx_overflow, 1);
      tx_count = 10; tick(); tick();
      chk("R11 sticky", tx_overflow, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      tick(); tick();
      rst_n = 1; tick();
      t_reset();
      t_rx_trig();
      t_rx_gate();
      t_dr();
      t_tx_half();
      t_tx_empty();
      t_clear();
      t_prio();
      t_tx_gate();
      t_ovf();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule